// File: doc/BRIEF.md
# PPS Monitor Register Interface

This block watches a one-pulse-per-second input and reports its health through a small register bus. The input is sampled on either the rising or the falling clock edge, resynchronised, and turned into a one-cycle system pulse. A free-running counter measures the clock cycles between successive system pulses. It latches that interval as the captured period and reports its own live value as the offset since the latest pulse.

Software programs an expected period and the sampling edge in a control word. At every system pulse the block compares the interval just measured with the expected value and sets or clears a stable flag. A status bit flips on every pulse, so a slow poller can tell that pulses are still arriving. When the input stops, the counter saturates, the captured period reads all ones and the stable flag drops. Everything runs on one clock. Read data returns one cycle after the read strobe.

Top module: `pps_monitor`

## Requirements
- R1: Address 0 is the status word. Bit 31 is the pulse toggle, bit 30 is the stable flag, bits CNT_W-1..0 hold the captured period, and all other bits read 0. CNT_W is clog2(CLK_FREQ)+1, which is 11 by default.
- R2: Address 1 is the control word. Bit 31 selects the sampling edge (0 = rising, 1 = falling), and bits 30..0 hold the expected period. The word reads back as written. After reset it holds edge 0 and expected period CLK_FREQ.
- R3: Address 2 returns the offset count in bits CNT_W-1..0, with the upper bits at 0. The offset is 1 in the cycle after a system pulse and N in the N-th cycle after it.
- R4: The captured period equals the number of clock cycles between two successive system pulses.
- R5: At each system pulse the stable flag is set if the interval just measured equals the expected period, and cleared otherwise.
- R6: Without pulses the run counter stops at 2^CNT_W-1. The captured period and the offset then both read that value, and the stable flag is 0.
- R7: The toggle bit inverts once per system pulse and holds its value between pulses.
- R8: The input changes 7 ns after a rising clock edge. Falling-edge sampling then produces the system pulse one cycle earlier than rising-edge sampling. Switching from rising to falling gives one interval of period-1, and switching back gives one interval of period+1.
- R9: Read data and a read-valid flag appear one cycle after the read strobe. Read-valid is 0 in cycles that follow no read, and address 3 reads 0.
- R10: Writes to any address other than 1 change no register.
- R11: The system pulse output is high for exactly one clock cycle per rising edge of the input.
- R12: After reset the status word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for sampling, counting and bus |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after bus_rd |
| pps_pulse | output | 1 | One-cycle system pulse per input pulse |

## Verification
The bench switches the sampling edge while pulses keep running. A design that ignores the select, or that takes the wrong half-cycle sample, would show no period-1 or period+1 interval, or would show it in the wrong direction. It stops the pulses for longer than the counter range. A counter that wraps instead of saturating would report a small period, and a flag that only updates on pulses would keep claiming stability. It also reads the offset 1, 250 and 600 cycles after a pulse, which exposes a counter that restarts at 0 or lags by a cycle. Finally, it writes all ones to the read-only addresses, so any leak into the control word would show up on readback.

// File: rtl/pps_mon_pkg.sv
package pps_mon_pkg;

  localparam int DATA_W = 32;
  localparam int EXP_W  = DATA_W - 1;

  localparam int SEL_STATUS = 0;
  localparam int SEL_CTRL   = 1;
  localparam int SEL_OFFSET = 2;

  typedef struct packed {
    logic             fall_edge;
    logic [EXP_W-1:0] expected;
  } ctrl_word_t;

  // Stable decision: the interval just measured against the programmed one
  function automatic logic period_match(input logic [EXP_W-1:0] expected,
                                        input logic [EXP_W-1:0] measured);
    return expected == measured;
  endfunction

  // Status word: toggle on top, stable below it, count at the bottom
  function automatic logic [DATA_W-1:0] pack_status(input logic tog,
                                                    input logic stable,
                                                    input logic [DATA_W-3:0] count);
    return {tog, stable, count};
  endfunction

endpackage

// File: rtl/pps_edge_capture.sv
module pps_edge_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_in,
  input  logic fall_sel,
  output logic pulse_o
);

  logic samp_pos;
  logic samp_neg;
  logic picked;
  logic [SYNC_STAGES-1:0] chain;
  logic last_lvl;
  logic rise_w;

  always_ff @(posedge clk) begin
    if (rst) samp_pos <= 1'b0;
    else     samp_pos <= pps_in;
  end

  always_ff @(negedge clk) begin
    if (rst) samp_neg <= 1'b0;
    else     samp_neg <= pps_in;
  end

  assign picked = fall_sel ? samp_neg : samp_pos;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= picked;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-2:0], picked};
      end
    end
  endgenerate

  assign rise_w = chain[SYNC_STAGES-1] & ~last_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_lvl <= 1'b0;
      pulse_o  <= 1'b0;
    end else begin
      last_lvl <= chain[SYNC_STAGES-1];
      pulse_o  <= rise_w;
    end
  end

  // R11: the system pulse never lasts two cycles
  p_pulse_one_wide_r11: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/pps_period_counter.sv
module pps_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] run_o,
  output logic [CNT_W-1:0] captured_o,
  output logic             sat_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max_w;

  assign at_max_w = (run_o == CNT_MAX);
  assign sat_o    = at_max_w & ~pulse_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o      <= '0;
      captured_o <= '0;
    end else begin
      if (pulse_i)        run_o <= CNT_W'(1);
      else if (!at_max_w) run_o <= run_o + CNT_W'(1);
      if (pulse_i)        captured_o <= run_o;
      else if (sat_o)     captured_o <= CNT_MAX;
    end
  end

  // R3: offset restarts at one right after a pulse
  p_offset_restart_r3: assert property (@(posedge clk) disable iff (rst)
    pulse_i |=> (run_o == CNT_W'(1)));

  // R6: once saturated without a pulse, the count stays pinned
  p_sat_holds_r6: assert property (@(posedge clk) disable iff (rst)
    sat_o |=> (run_o == CNT_MAX) && (captured_o == CNT_MAX));

  // R4: captured value changes only at a pulse or saturation
  p_capture_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!pulse_i && !sat_o) |=> $stable(captured_o));

endmodule

// File: rtl/pps_mon_regs.sv
module pps_mon_regs
  import pps_mon_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int ADDR_W   = 2,
  parameter int CLK_FREQ = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse_i,
  input  logic              sat_i,
  input  logic [CNT_W-1:0]  run_i,
  input  logic [CNT_W-1:0]  captured_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              fall_sel_o
);

  localparam int PAD_W = DATA_W - CNT_W;
  localparam logic [EXP_W-1:0] EXP_RESET = EXP_W'(CLK_FREQ);

  ctrl_word_t         ctrl_q;
  logic               stable_q;
  logic               tog_q;
  logic               ctrl_wr_w;
  logic               match_w;
  logic [DATA_W-1:0]  status_w;
  logic [DATA_W-1:0]  offset_w;
  logic [DATA_W-1:0]  rd_mux_w;

  assign ctrl_wr_w  = bus_wr && (bus_addr == ADDR_W'(SEL_CTRL));
  assign match_w    = period_match(ctrl_q.expected, EXP_W'(run_i));
  assign status_w   = pack_status(tog_q, stable_q, (DATA_W-2)'(captured_i));
  assign offset_w   = {{PAD_W{1'b0}}, run_i};
  assign fall_sel_o = ctrl_q.fall_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.fall_edge <= 1'b0;
      ctrl_q.expected  <= EXP_RESET;
    end else if (ctrl_wr_w) begin
      ctrl_q <= ctrl_word_t'(bus_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stable_q <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      if (pulse_i)    stable_q <= match_w;
      else if (sat_i) stable_q <= 1'b0;
      if (pulse_i)    tog_q <= ~tog_q;
    end
  end

  always_comb begin
    rd_mux_w = '0;
    if (bus_addr == ADDR_W'(SEL_STATUS))      rd_mux_w = status_w;
    else if (bus_addr == ADDR_W'(SEL_CTRL))   rd_mux_w = ctrl_q;
    else if (bus_addr == ADDR_W'(SEL_OFFSET)) rd_mux_w = offset_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux_w;
    end
  end

  // R7: toggle flips on a pulse and holds otherwise
  p_toggle_flip_r7: assert property (@(posedge clk) disable iff (rst)
    pulse_i |=> (tog_q != $past(tog_q)));
  p_toggle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !pulse_i |=> $stable(tog_q));

  // R5: stability can only be gained at a pulse
  p_stable_at_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stable_q) |-> $past(pulse_i));

  // R6: saturation drops the stable flag
  p_sat_clears_r6: assert property (@(posedge clk) disable iff (rst)
    sat_i |=> !stable_q);

  // R9: read-valid follows the strobe by one cycle
  p_rvalid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_rvalid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  // R10: writes elsewhere leave the control word alone
  p_ctrl_guard_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr != ADDR_W'(SEL_CTRL))) |=> $stable(ctrl_q));

endmodule

// File: rtl/pps_monitor.sv
module pps_monitor
  import pps_mon_pkg::*;
#(
  parameter int CLK_FREQ    = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pps_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              pps_pulse
);

  localparam int CNT_W = $clog2(CLK_FREQ) + 1;

  logic             fall_sel_w;
  logic             pulse_w;
  logic             sat_w;
  logic [CNT_W-1:0] run_w;
  logic [CNT_W-1:0] captured_w;

  pps_edge_capture #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_capture (
    .clk     (clk),
    .rst     (rst),
    .pps_in  (pps_in),
    .fall_sel(fall_sel_w),
    .pulse_o (pulse_w)
  );

  pps_period_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk       (clk),
    .rst       (rst),
    .pulse_i   (pulse_w),
    .run_o     (run_w),
    .captured_o(captured_w),
    .sat_o     (sat_w)
  );

  pps_mon_regs #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .CLK_FREQ(CLK_FREQ)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .pulse_i   (pulse_w),
    .sat_i     (sat_w),
    .run_i     (run_w),
    .captured_i(captured_w),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .fall_sel_o(fall_sel_w)
  );

  assign pps_pulse = pulse_w;

endmodule

// File: tb/test_pps_monitor.sv
`timescale 1ns/1ps
module test_pps_monitor;

  localparam int FREQ   = 1000;
  localparam int CW     = $clog2(FREQ) + 1;
  localparam int SATV   = (1 << CW) - 1;
  localparam int NVEC   = 5;
  localparam int V_EDGE [NVEC] = '{0, 0, 1, 1, 0};
  localparam int V_EXP  [NVEC] = '{1000, 1000, 500, 1000, 64};
  localparam int V_PER  [NVEC] = '{1000, 998, 500, 1003, 64};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pps_in = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        pps_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  int n_pulse = 0;
  int n_wide = 0;
  logic prev_pulse = 1'b0;
  logic gen_on = 1'b0;
  int gen_period = 1000;
  int gen_phase = 0;
  logic [31:0] rd;
  logic rv;

  always #10 clk = ~clk;

  pps_monitor #(.CLK_FREQ(FREQ)) i_pps_monitor (
    .clk(clk), .rst(rst), .pps_in(pps_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pps_pulse(pps_pulse)
  );

  // Pulse generator: rises 7 ns after a rising clock edge, high for 4 cycles
  initial begin
    forever begin
      @(posedge clk);
      #7;
      if (!gen_on) begin
        pps_in = 1'b0;
        gen_phase = 0;
      end else begin
        if (gen_phase == 0) pps_in = 1'b1;
        if (gen_phase == 4) pps_in = 1'b0;
        gen_phase = (gen_phase + 1 == gen_period) ? 0 : gen_phase + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (pps_pulse) n_pulse++;
      if (pps_pulse && prev_pulse) n_wide++;
      prev_pulse = pps_pulse;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = 2'(addr); bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] data, output logic valid);
    @(negedge clk);
    bus_addr = 2'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = bus_rdata; valid = bus_rvalid;
  endtask

  task automatic wait_pulse();
    @(negedge clk);
    while (!pps_pulse) @(negedge clk);
  endtask

  function automatic logic [31:0] ctrl_word(input int edge_sel, input int expv);
    return {edge_sel[0], 31'(expv)};
  endfunction

  // Read status after a pulse and compare each field
  task automatic check_status(input string tag, input int cnt, input int stab);
    bus_read(0, rd, rv);
    check({"R4 count ", tag}, 32'(rd[CW-1:0]), 32'(cnt));
    check({"R5 stable ", tag}, 32'(rd[30]), 32'(stab));
    check({"R7 toggle ", tag}, 32'(rd[31]), 32'(n_pulse & 1));
    check({"R1 pad ", tag}, rd[29:CW], '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (3) @(posedge clk);

    // R12 / R2: reset state
    bus_read(0, rd, rv);
    check("R12 status after reset", rd, 32'h0);
    bus_read(1, rd, rv);
    check("R2 ctrl after reset", rd, ctrl_word(0, FREQ));
    check("R9 rvalid with read", 32'(rv), 32'd1);
    @(negedge clk);
    check("R9 rvalid idle", 32'(bus_rvalid), 32'd0);
    bus_read(3, rd, rv);
    check("R9 address 3 zero", rd, 32'h0);

    // Table-driven steady runs
    for (int v = 0; v < NVEC; v++) begin
      gen_on = 1'b0;
      bus_write(1, ctrl_word(V_EDGE[v], V_EXP[v]));
      bus_read(1, rd, rv);
      check("R2 ctrl readback", rd, ctrl_word(V_EDGE[v], V_EXP[v]));
      gen_period = V_PER[v];
      gen_on = 1'b1;
      repeat (3) wait_pulse();
      check_status($sformatf("vec%0d", v), V_PER[v], (V_PER[v] == V_EXP[v]) ? 1 : 0);
    end

    // R8: switching the sampling edge mid-stream
    gen_on = 1'b0;
    bus_write(1, ctrl_word(0, 1000));
    gen_period = 1000;
    gen_on = 1'b1;
    repeat (3) wait_pulse();
    check_status("R8 base", 1000, 1);
    repeat (20) @(posedge clk);
    bus_write(1, ctrl_word(1, 1000));
    wait_pulse();
    check_status("R8 to falling", 999, 0);
    wait_pulse();
    check_status("R8 falling steady", 1000, 1);
    repeat (20) @(posedge clk);
    bus_write(1, ctrl_word(0, 1000));
    wait_pulse();
    check_status("R8 to rising", 1001, 0);
    wait_pulse();
    check_status("R8 rising steady", 1000, 1);

    // R6: missing pulses saturate the counter
    gen_on = 1'b0;
    repeat (SATV + 100) @(posedge clk);
    check_status("R6 saturated", SATV, 0);
    bus_read(2, rd, rv);
    check("R6 offset saturated", rd, 32'(SATV));

    // R3: offset count after a pulse
    gen_period = 1000;
    gen_on = 1'b1;
    wait_pulse();
    repeat (1) @(posedge clk);
    bus_read(2, rd, rv);
    check("R3 offset 1", rd, 32'd1);
    wait_pulse();
    repeat (250) @(posedge clk);
    bus_read(2, rd, rv);
    check("R3 offset 250", rd, 32'd250);
    wait_pulse();
    repeat (600) @(posedge clk);
    bus_read(2, rd, rv);
    check("R3 offset 600", rd, 32'd600);

    // R10: writes to read-only addresses are ignored
    gen_on = 1'b0;
    bus_write(0, 32'hFFFF_FFFF);
    bus_write(2, 32'hFFFF_FFFF);
    bus_write(3, 32'hFFFF_FFFF);
    bus_read(1, rd, rv);
    check("R10 ctrl unchanged", rd, ctrl_word(0, 1000));
    bus_read(0, rd, rv);
    check("R10 status toggle unchanged", 32'(rd[31]), 32'(n_pulse & 1));

    // R11: no pulse was ever two cycles wide, and pulses were seen
    check("R11 wide pulses", 32'(n_wide), 32'd0);
    check("R11 pulses seen", 32'(n_pulse > 20), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule